// File: doc/BRIEF.md
# Burst configuration command decoder

This block sits at the front of the command register of a NOR flash model. It watches the host write cycles and picks out the one command sequence that sets burst behaviour. The sequence has two unlock writes followed by a write of C0h. The third write carries its setting in the address: bits A16–A15 choose the burst mode and bits A14–A12 choose the wait-state code for the initial access. Every other write pattern aborts the sequence. The decoder then returns to its idle read-array state and leaves the stored setting untouched.

The host strobes are active low and asynchronous. The address-valid strobe and the write-enable strobe each pass through two flip-flops into the system clock, and only their rising edges are used. The address is latched on a rising edge of the address-valid strobe. The data is sampled, and the write is evaluated, on a rising edge of the write-enable strobe. The stored setting is offered as registered outputs in the system clock domain: the mode, the burst length in words and the initial latency in clocks. A one-cycle pulse marks each update.

Top module: `burst_cfg_cmd`

## Requirements
- R1: After reset, burst_mode is 00 (continuous), burst_len is 0, latency is 7 and cfg_update is low.
- R2: The three writes AAh to word address 555h, then 55h to 2AAh, then C0h to an address whose bits A11–A0 are 555h update the register. burst_mode takes A16–A15 and latency takes the value of A14–A12 plus 2.
- R3: burst_len follows burst_mode: 00 gives 0 (continuous), 01 gives 8, 10 gives 16 and 11 gives 32.
- R4: Address bits above A10 are ignored in the two unlock writes. Bits A19–A17 are ignored in the third write. For example, 0B555h and E B555h both select mode 01 with latency 5.
- R5: A wrong data value in any of the three writes aborts the sequence. The outputs stay unchanged and no pulse is issued.
- R6: A wrong address in any of the three writes aborts the sequence. The outputs stay unchanged and no pulse is issued.
- R7: A third write with wait-state code 6 or 7 aborts the sequence and leaves the outputs unchanged.
- R8: Writes in the wrong order do not update the register. After any abort, a complete, correct sequence is accepted again.
- R9: cfg_update pulses high for exactly one clock cycle per accepted sequence. The outputs change only in the cycle in which cfg_update is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| avd_n | input | 1 | Active-low address-valid strobe; the address is latched when it rises |
| we_n | input | 1 | Active-low write strobe; the data is taken and the write evaluated when it rises |
| addr | input | ADDR_W | Host word address |
| wdata | input | DATA_W | Host write data |
| burst_mode | output | 2 | Stored burst mode |
| burst_len | output | 6 | Burst length in words, 0 for continuous |
| latency | output | 3 | Initial access latency in clocks (2 to 7) |
| cfg_update | output | 1 | One-cycle pulse when a new setting is stored |

## Verification
The checks assume that the address stays steady from the fall of the address-valid strobe until a few clocks after it rises. They also assume that the data stays steady around the rise of the write strobe, and that each strobe stays low and then high for several clocks so that both synchronizers see every edge. The stimulus tasks hold each bus value for several clocks on both sides of every strobe edge. They never overlap a write strobe with an address strobe. Random sequences may be valid, carry a bad wait-state code, or have their data or address corrupted at a random step. They are mixed with directed cases for don't-care address bits and for wrong ordering.

// File: rtl/burst_cfg_cmd.sv
module burst_cfg_cmd #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              avd_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [1:0]        burst_mode,
  output logic [5:0]        burst_len,
  output logic [2:0]        latency,
  output logic              cfg_update
);
  localparam logic [10:0] UNLOCK_A = 11'h555;
  localparam logic [10:0] UNLOCK_B = 11'h2AA;
  localparam logic [11:0] CMD_LOW  = 12'h555;
  localparam logic [DATA_W-1:0] KEY_A   = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] KEY_B   = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] KEY_CFG = DATA_W'(8'hC0);

  typedef enum logic [1:0] {ST_IDLE, ST_UNL1, ST_UNL2} seq_t;

  logic [2:0] avd_sh, we_sh;
  logic avd_rise, we_rise;
  logic [ADDR_W-1:0] addr_q;
  seq_t state;
  logic [1:0] mode_sel;
  logic [2:0] ws_code;
  logic cfg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avd_sh <= 3'b111;
      we_sh  <= 3'b111;
    end else begin
      avd_sh <= {avd_sh[1:0], avd_n};
      we_sh  <= {we_sh[1:0], we_n};
    end
  end

  assign avd_rise = avd_sh[1] & ~avd_sh[2];
  assign we_rise  = we_sh[1] & ~we_sh[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (avd_rise) addr_q <= addr;
  end

  assign mode_sel = addr_q[16:15];
  assign ws_code  = addr_q[14:12];
  assign cfg_ok   = (state == ST_UNL2) && (addr_q[11:0] == CMD_LOW) &&
                    (wdata == KEY_CFG) && (ws_code <= 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (we_rise) begin
      case (state)
        ST_IDLE: state <= (addr_q[10:0] == UNLOCK_A && wdata == KEY_A) ? ST_UNL1 : ST_IDLE;
        ST_UNL1: state <= (addr_q[10:0] == UNLOCK_B && wdata == KEY_B) ? ST_UNL2 : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_mode <= 2'b00;
      burst_len  <= 6'd0;
      latency    <= 3'd7;
      cfg_update <= 1'b0;
    end else begin
      cfg_update <= we_rise && cfg_ok;
      if (we_rise && cfg_ok) begin
        burst_mode <= mode_sel;
        burst_len  <= (mode_sel == 2'b00) ? 6'd0 : (6'd4 << mode_sel);
        latency    <= ws_code + 3'd2;
      end
    end
  end
endmodule

module burst_cfg_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] burst_mode,
  input logic [5:0] burst_len,
  input logic [2:0] latency,
  input logic       cfg_update
);
  // R1
  latency_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latency >= 3'd2);

  // R3
  len_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_len == ((burst_mode == 2'b00) ? 6'd0 : (6'd4 << burst_mode)));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update |=> !cfg_update);

  // R9
  hold_without_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_update |-> $stable({burst_mode, burst_len, latency}));
endmodule

bind burst_cfg_cmd burst_cfg_cmd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .burst_len(burst_len),
  .latency(latency), .cfg_update(cfg_update)
);

// File: tb/burst_cfg_cmd_tb_top.sv
module burst_cfg_cmd_tb_top;
  logic clk = 0, rst_n = 0, avd_n = 1, we_n = 1;
  logic [19:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] burst_mode;
  logic [5:0] burst_len;
  logic [2:0] latency;
  logic cfg_update;

  int checks = 0, fails = 0, pulses = 0, exp_pulses = 0;
  int step = 0;
  logic [1:0] e_mode = 0;
  logic [2:0] e_lat = 7;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_cfg_cmd dut_i (.clk(clk), .rst_n(rst_n), .avd_n(avd_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .burst_mode(burst_mode), .burst_len(burst_len),
    .latency(latency), .cfg_update(cfg_update));

  always @(posedge clk) if (rst_n && cfg_update) pulses++;

  function automatic logic [5:0] len_of(logic [1:0] m);
    case (m) 2'd0: return 0; 2'd1: return 8; 2'd2: return 16; default: return 32; endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(logic [19:0] a, logic [7:0] d);
    case (step)
      0: step = (a[10:0] == 11'h555 && d == 8'hAA) ? 1 : 0;
      1: step = (a[10:0] == 11'h2AA && d == 8'h55) ? 2 : 0;
      default: begin
        if (a[11:0] == 12'h555 && d == 8'hC0 && a[14:12] <= 3'd5) begin
          e_mode = a[16:15];
          e_lat = a[14:12] + 3'd2;
          exp_pulses++;
        end
        step = 0;
      end
    endcase
  endtask

  task automatic wr(logic [19:0] a, logic [7:0] d);
    @(negedge clk); addr = a; avd_n = 0;
    repeat (3) @(negedge clk); avd_n = 1;
    repeat (4) @(negedge clk); wdata = d; we_n = 0;
    repeat (3) @(negedge clk); we_n = 1;
    repeat (5) @(negedge clk);
    model(a, d);
  endtask

  task automatic seq(logic [19:0] a3, logic [7:0] d3);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(a3, d3);
  endtask

  task automatic check_all(string tag);
    chk({tag, " mode"}, burst_mode, e_mode);
    chk({tag, " len"}, burst_len, len_of(e_mode));
    chk({tag, " lat"}, latency, e_lat);
    chk({tag, " pulses"}, pulses, exp_pulses);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode", burst_mode, 0); chk("R1 len", burst_len, 0);
    chk("R1 lat", latency, 7); chk("R1 pulse", cfg_update, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    seq(20'h0B555, 8'hC0); check_all("R2 0B555");
    chk("R4 example lat", latency, 5);
    seq(20'h10555, 8'hC0); check_all("R3 16w");
    seq(20'h1D555, 8'hC0); check_all("R3 32w");
    seq(20'h02555, 8'hC0); check_all("R3 cont");
    wr(20'hF8555, 8'hAA); wr(20'h7F2AA, 8'h55); wr(20'hE9555, 8'hC0);
    check_all("R4 high bits");
    chk("R4 mode", burst_mode, 1); chk("R4 lat", latency, 3);
    seq(20'h0E555, 8'hC0); check_all("R7 code6");
    seq(20'h1F555, 8'hC0); check_all("R7 code7");
    seq(20'h0C555, 8'hC1); check_all("R5 data3");
    seq(20'h0C556, 8'hC0); check_all("R6 addr3");
    wr(20'h002AA, 8'h55); wr(20'h00555, 8'hAA); wr(20'h0C555, 8'hC0);
    check_all("R8 order");
    seq(20'h0C555, 8'hC0); check_all("R8 recover");

    for (int i = 0; i < 200; i++) begin
      int kind = $urandom_range(0, 3);
      int bad = $urandom_range(0, 2);
      logic [19:0] a[3];
      logic [7:0] d[3];
      a[0] = {$urandom_range(0, 511), 11'h555}; d[0] = 8'hAA;
      a[1] = {$urandom_range(0, 511), 11'h2AA}; d[1] = 8'h55;
      a[2] = {3'($urandom), 2'($urandom), 3'($urandom_range(0, 5)), 12'h555};
      d[2] = 8'hC0;
      if (kind == 1) a[2][14:12] = 3'($urandom_range(6, 7));
      if (kind == 2) d[bad] = d[bad] ^ 8'($urandom_range(1, 255));
      if (kind == 3) a[bad] = a[bad] ^ 20'(1 << $urandom_range(0, 10));
      for (int k = 0; k < 3; k++) wr(a[k], d[k]);
      check_all(kind == 0 ? "R2 rand" : kind == 1 ? "R7 rand" : kind == 2 ? "R5 rand" : "R6 rand");
    end

    chk("R9 pulse count", pulses, exp_pulses);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule